// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block moves outgoing frames from host memory to a byte stream. Software builds a ring of 16-byte descriptors at a base address and hands descriptors to hardware by setting their owner bit. It then strobes the poll input. The engine walks the ring from its current index for as long as it finds hardware-owned descriptors. For each one it fetches the control word and the buffer pointer, reads the segment data word by word, and appends the bytes to an internal gather buffer.

A descriptor flagged as the first segment of a frame empties the gather buffer before its data goes in. A descriptor flagged as the last segment makes the engine send the gathered frame out, one byte per cycle. A loop flag travels with the stream so the consumer can route the frame to the receive path instead of the line. After each descriptor the engine writes word 0 back with the owner bit cleared and pulses any status request carried in the descriptor. It then advances or wraps its index. When the engine reaches a descriptor that software still owns, it pulses the no-buffer status and goes idle.

Top module: `txr_engine`

## Requirements
- R1: A poll strobe starts a ring scan only when both tx_en_i and dma_en_i are high. A poll that arrives while the engine is idle and either enable is low is dropped: it starts no memory access, then or later.
- R2: A scan reads word 0 of the descriptor at ring_base_i + 16 × index, and then reads word 1 at +4 and word 2 (the buffer address, word aligned) at +8. The index is 0 after reset.
- R3: When the word 0 read returns bit 31 low, the engine pulses st_nobuf_o for one cycle, writes nothing back and goes idle.
- R4: Every descriptor whose word 0 bit 31 is high gets a write of word 0 after its data is processed. The written word has bit 31 low and bit 0 equal to the truncation flag of that descriptor; all other bits are zero.
- R5: Word 1 bits [10:0] give the segment length in bytes. Segment data is read little-endian, with byte k of a word at bits [8k+7:8k]. Word 1 bit 28 (first segment) empties the gather buffer before the data is added. Without that bit, the segment is appended after the bytes already gathered.
- R6: When word 1 bit 27 (last segment) is set, the gathered frame is sent on frm_data_o with frm_valid_o high for one byte per cycle, in order. frm_last_o marks the final byte, and frm_loop_o equals loop_en_i as it was when the frame started.
- R7: After the write-back of a descriptor, word 1 bit 29 causes a one-cycle pulse on st_txok_o and word 1 bit 30 causes a one-cycle pulse on st_done_o.
- R8: After a descriptor with word 1 bit 31 (end of ring) the index becomes 0; after any other processed descriptor it increments. The index is kept between scans.
- R9: The gather buffer holds DEPTH bytes. Bytes beyond DEPTH are discarded, the frame is cut to DEPTH bytes, and that descriptor's write-back has bit 0 set.
- R10: A poll strobe received during a scan is remembered and starts exactly one further scan after the current one stops.
- R11: A memory request holds mem_req_o, mem_we_o and mem_addr_o steady until the cycle in which mem_ack_i is high.
- R12: After reset the engine is idle: no memory request, no frame byte and no status pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| poll_i | input | 1 | Poll-demand strobe |
| ring_base_i | input | 32 | Byte address of descriptor 0 |
| tx_en_i | input | 1 | Transmit enable |
| dma_en_i | input | 1 | Transmit DMA enable |
| loop_en_i | input | 1 | Route frames to the receive path |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request completed; read data valid |
| mem_rdata_i | input | 32 | Read data |
| frm_valid_o | output | 1 | Frame byte valid |
| frm_data_o | output | 8 | Frame byte |
| frm_last_o | output | 1 | Final byte of the frame |
| frm_loop_o | output | 1 | Frame goes to the receive path |
| st_txok_o | output | 1 | Transmit-ok status pulse |
| st_done_o | output | 1 | Transmit-finish status pulse |
| st_nobuf_o | output | 1 | No-buffer status pulse |

## Verification
The rings tried include a single-descriptor frame, a three-segment frame that ends on an end-of-ring descriptor, and a reuse of slot 0 after the wrap. Together they separate appending from clearing, increment from wrap, and the line path from loopback. An oversized segment shows whether the frame is cut at the buffer depth and whether the error bit appears in the write-back. A short frame after it shows whether the first-segment flag really empties the buffer. Polls given with either enable low must leave memory untouched. A second poll given mid-scan must produce exactly one extra no-buffer pulse and no extra frame.

// File: rtl/txr_pkg.sv
package txr_pkg;

    localparam int OWN_BIT = 31;

    typedef enum logic [2:0] {
        S_IDLE, S_RD0, S_RD1, S_RD2, S_DATA, S_SEG, S_EMIT, S_WB
    } txr_state_e;

    typedef struct packed {
        logic        eor;
        logic        fin_irq;
        logic        ok_irq;
        logic        first;
        logic        last;
        logic [10:0] len;
    } txr_ctl_t;

    function automatic txr_ctl_t decode_ctl(input logic [31:0] w);
        txr_ctl_t c;
        c.eor     = w[31];
        c.fin_irq = w[30];
        c.ok_irq  = w[29];
        c.first   = w[28];
        c.last    = w[27];
        c.len     = w[10:0];
        return c;
    endfunction

    function automatic logic [2:0] seg_take(input logic [10:0] rem);
        return (rem >= 11'd4) ? 3'd4 : rem[2:0];
    endfunction

endpackage

// File: rtl/txr_ring_ptr.sv
module txr_ring_ptr #(
    parameter int IDXW = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        adv,
    input  logic        wrap,
    input  logic [31:0] base,
    output logic [31:0] desc_addr
);
    localparam int PADW = 32 - IDXW - 4;

    logic [IDXW-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst)
            idx <= '0;
        else if (adv)
            idx <= wrap ? '0 : idx + 1'b1;
    end

    assign desc_addr = base + {{PADW{1'b0}}, idx, 4'b0000};

endmodule

// File: rtl/txr_gather.sv
module txr_gather #(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          wr,
    input  logic [31:0]   wdata,
    input  logic [2:0]    wcnt,
    input  logic [AW-1:0] rd_idx,
    output logic [7:0]    rd_byte,
    output logic [LW-1:0] len,
    output logic          ovf
);
    logic [7:0]  store [DEPTH];
    logic [LW:0] sum;

    assign sum = {1'b0, len} + (LW+1)'(wcnt);
    assign ovf = wr && (sum > (LW+1)'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst || clr)
            len <= '0;
        else if (wr)
            len <= ovf ? LW'(DEPTH) : sum[LW-1:0];
    end

    always_ff @(posedge clk) begin
        if (wr) begin
            for (int k = 0; k < 4; k++) begin
                logic [LW:0] pos;
                pos = {1'b0, len} + (LW+1)'(k);
                if (3'(k) < wcnt && pos < (LW+1)'(DEPTH))
                    store[AW'(pos)] <= wdata[8*k +: 8];
            end
        end
    end

    assign rd_byte = store[rd_idx];

    // R9
    len_cap_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |=> (len == LW'(DEPTH)));

endmodule

// File: rtl/txr_seq.sv
module txr_seq
    import txr_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          poll_i,
    input  logic          tx_en_i,
    input  logic          dma_en_i,
    input  logic          loop_en_i,
    input  logic [31:0]   desc_addr,
    output logic          ptr_adv,
    output logic          ptr_wrap,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [31:0]   mem_addr_o,
    output logic [31:0]   mem_wdata_o,
    input  logic          mem_ack_i,
    input  logic [31:0]   mem_rdata_i,
    output logic          gl_clr,
    output logic          gl_wr,
    output logic [31:0]   gl_wdata,
    output logic [2:0]    gl_wcnt,
    output logic [AW-1:0] gl_rd,
    input  logic [7:0]    gl_byte,
    input  logic [LW-1:0] gl_len,
    input  logic          gl_ovf,
    output logic          frm_valid_o,
    output logic [7:0]    frm_data_o,
    output logic          frm_last_o,
    output logic          frm_loop_o,
    output logic          st_txok_o,
    output logic          st_done_o,
    output logic          st_nobuf_o
);
    txr_state_e    state;
    txr_ctl_t      ctl;
    logic          pend;
    logic [31:0]   bufp;
    logic [10:0]   rem;
    logic          err;
    logic [AW-1:0] ocnt;
    logic          loop_r;
    logic [2:0]    take;
    logic          enabled;

    assign enabled = tx_en_i && dma_en_i;
    assign take    = seg_take(rem);

    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = desc_addr;
        mem_wdata_o = {31'b0, err};
        unique case (state)
            S_RD0:  mem_req_o = 1'b1;
            S_RD1:  begin mem_req_o = 1'b1; mem_addr_o = desc_addr + 32'd4; end
            S_RD2:  begin mem_req_o = 1'b1; mem_addr_o = desc_addr + 32'd8; end
            S_DATA: begin mem_req_o = (rem != 11'd0); mem_addr_o = bufp; end
            S_WB:   begin mem_req_o = 1'b1; mem_we_o = 1'b1; end
            default: ;
        endcase
    end

    assign gl_clr   = (state == S_RD2) && mem_ack_i && ctl.first;
    assign gl_wr    = (state == S_DATA) && (rem != 11'd0) && mem_ack_i;
    assign gl_wdata = mem_rdata_i;
    assign gl_wcnt  = take;
    assign gl_rd    = ocnt;

    assign ptr_adv  = (state == S_WB) && mem_ack_i;
    assign ptr_wrap = ctl.eor;

    assign frm_valid_o = (state == S_EMIT);
    assign frm_data_o  = gl_byte;
    assign frm_last_o  = (state == S_EMIT) && (LW'(ocnt) == gl_len - 1'b1);
    assign frm_loop_o  = loop_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            ctl        <= '0;
            pend       <= 1'b0;
            bufp       <= '0;
            rem        <= '0;
            err        <= 1'b0;
            ocnt       <= '0;
            loop_r     <= 1'b0;
            st_txok_o  <= 1'b0;
            st_done_o  <= 1'b0;
            st_nobuf_o <= 1'b0;
        end else begin
            st_txok_o  <= 1'b0;
            st_done_o  <= 1'b0;
            st_nobuf_o <= 1'b0;
            if (state != S_IDLE && poll_i)
                pend <= 1'b1;
            unique case (state)
                S_IDLE: begin
                    if (poll_i || pend) begin
                        pend <= 1'b0;
                        if (enabled)
                            state <= S_RD0;
                    end
                end
                S_RD0: if (mem_ack_i) begin
                    err <= 1'b0;
                    if (mem_rdata_i[OWN_BIT]) begin
                        state <= S_RD1;
                    end else begin
                        st_nobuf_o <= 1'b1;
                        state      <= S_IDLE;
                    end
                end
                S_RD1: if (mem_ack_i) begin
                    ctl   <= decode_ctl(mem_rdata_i);
                    state <= S_RD2;
                end
                S_RD2: if (mem_ack_i) begin
                    bufp  <= mem_rdata_i;
                    rem   <= ctl.len;
                    state <= S_DATA;
                end
                S_DATA: begin
                    if (rem == 11'd0) begin
                        state <= S_SEG;
                    end else if (mem_ack_i) begin
                        rem  <= rem - {8'b0, take};
                        bufp <= bufp + 32'd4;
                        if (gl_ovf)
                            err <= 1'b1;
                    end
                end
                S_SEG: begin
                    ocnt   <= '0;
                    loop_r <= loop_en_i;
                    state  <= (ctl.last && gl_len != '0) ? S_EMIT : S_WB;
                end
                S_EMIT: begin
                    if (frm_last_o)
                        state <= S_WB;
                    else
                        ocnt <= ocnt + 1'b1;
                end
                S_WB: if (mem_ack_i) begin
                    st_txok_o <= ctl.ok_irq;
                    st_done_o <= ctl.fin_irq;
                    state     <= S_RD0;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_ack_i) |=>
            (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

    // R4
    wb_owner_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && mem_we_o) |-> !mem_wdata_o[OWN_BIT]);

    // R6
    emit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        frm_valid_o |-> !mem_req_o);

    // R3
    stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
        st_nobuf_o |-> (!mem_req_o && !frm_valid_o && !st_txok_o && !st_done_o));

    // R1
    gate_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && !enabled) |=> (state == S_IDLE));

endmodule

// File: rtl/txr_engine.sv
module txr_engine #(
    parameter int DEPTH = 2048,
    parameter int IDXW  = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        poll_i,
    input  logic [31:0] ring_base_i,
    input  logic        tx_en_i,
    input  logic        dma_en_i,
    input  logic        loop_en_i,
    output logic        mem_req_o,
    output logic        mem_we_o,
    output logic [31:0] mem_addr_o,
    output logic [31:0] mem_wdata_o,
    input  logic        mem_ack_i,
    input  logic [31:0] mem_rdata_i,
    output logic        frm_valid_o,
    output logic [7:0]  frm_data_o,
    output logic        frm_last_o,
    output logic        frm_loop_o,
    output logic        st_txok_o,
    output logic        st_done_o,
    output logic        st_nobuf_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH + 1);

    logic [31:0]   desc_addr;
    logic          ptr_adv, ptr_wrap;
    logic          gl_clr, gl_wr, gl_ovf;
    logic [31:0]   gl_wdata;
    logic [2:0]    gl_wcnt;
    logic [AW-1:0] gl_rd;
    logic [7:0]    gl_byte;
    logic [LW-1:0] gl_len;

    txr_ring_ptr #(.IDXW(IDXW)) u_ptr (
        .clk(clk), .rst(rst), .adv(ptr_adv), .wrap(ptr_wrap),
        .base(ring_base_i), .desc_addr(desc_addr)
    );

    txr_gather #(.DEPTH(DEPTH)) u_gather (
        .clk(clk), .rst(rst), .clr(gl_clr), .wr(gl_wr), .wdata(gl_wdata),
        .wcnt(gl_wcnt), .rd_idx(gl_rd), .rd_byte(gl_byte), .len(gl_len),
        .ovf(gl_ovf)
    );

    txr_seq #(.DEPTH(DEPTH)) u_seq (
        .clk(clk), .rst(rst), .poll_i(poll_i), .tx_en_i(tx_en_i),
        .dma_en_i(dma_en_i), .loop_en_i(loop_en_i), .desc_addr(desc_addr),
        .ptr_adv(ptr_adv), .ptr_wrap(ptr_wrap),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
        .mem_rdata_i(mem_rdata_i),
        .gl_clr(gl_clr), .gl_wr(gl_wr), .gl_wdata(gl_wdata),
        .gl_wcnt(gl_wcnt), .gl_rd(gl_rd), .gl_byte(gl_byte),
        .gl_len(gl_len), .gl_ovf(gl_ovf),
        .frm_valid_o(frm_valid_o), .frm_data_o(frm_data_o),
        .frm_last_o(frm_last_o), .frm_loop_o(frm_loop_o),
        .st_txok_o(st_txok_o), .st_done_o(st_done_o),
        .st_nobuf_o(st_nobuf_o)
    );

endmodule

// File: tb/test_txr_engine.sv
module test_txr_engine;

    localparam int DEPTH = 64;
    localparam int BASE  = 32'h40;
    localparam logic [31:0] F_EOR = 32'h8000_0000, F_FIN = 32'h4000_0000,
                            F_OK  = 32'h2000_0000, F_FST = 32'h1000_0000,
                            F_LST = 32'h0800_0000, F_OWN = 32'h8000_0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic poll = 1'b0, tx_en = 1'b0, dma_en = 1'b0, loop_en = 1'b0;
    logic mem_req, mem_we, mem_ack, frm_valid, frm_last, frm_loop;
    logic st_txok, st_done, st_nobuf;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [7:0]  frm_data;

    always #2.5 clk = ~clk;

    txr_engine #(.DEPTH(DEPTH)) i_txr_engine (
        .clk(clk), .rst(rst), .poll_i(poll), .ring_base_i(BASE),
        .tx_en_i(tx_en), .dma_en_i(dma_en), .loop_en_i(loop_en),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
        .frm_valid_o(frm_valid), .frm_data_o(frm_data), .frm_last_o(frm_last),
        .frm_loop_o(frm_loop), .st_txok_o(st_txok), .st_done_o(st_done),
        .st_nobuf_o(st_nobuf)
    );

    logic [31:0] mem [0:1023];
    logic [7:0]  cap [0:511];
    int cap_n = 0, frames = 0, req_cnt = 0, ok_cnt = 0, fin_cnt = 0, nobuf_cnt = 0;
    logic loop_seen = 1'b0;
    int errors = 0, checks = 0;

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 13 + 5) & 255);
    endfunction

    // memory model: one-cycle acknowledge
    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
            mem_rdata <= '0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[11:2]];
        end else begin
            mem_ack <= 1'b0;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (frm_valid) begin
                if (cap_n < 512) cap[cap_n] = frm_data;
                cap_n++;
                loop_seen = frm_loop;
                if (frm_last) frames++;
            end
            if (mem_req)  req_cnt++;
            if (st_txok)  ok_cnt++;
            if (st_done)  fin_cnt++;
            if (st_nobuf) nobuf_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic put_desc(input int i, input logic [31:0] w0,
                            input logic [31:0] w1, input logic [31:0] b);
        int w = (BASE + 16 * i) / 4;
        mem[w] = w0; mem[w + 1] = w1; mem[w + 2] = b;
    endtask

    function automatic logic [31:0] desc_w0(input int i);
        return mem[(BASE + 16 * i) / 4];
    endfunction

    task automatic poll_once();
        @(negedge clk) poll = 1'b1;
        @(negedge clk) poll = 1'b0;
    endtask

    task automatic wait_nobuf(input int target, input string req);
        int n = 0;
        while (nobuf_cnt < target && n < 5000) begin
            @(negedge clk);
            n++;
        end
        repeat (4) @(negedge clk);
        chk(nobuf_cnt == target, req, "no-buffer pulses", nobuf_cnt, target);
    endtask

    task automatic chk_seg(input int start, input int b, input int len, input string req);
        int bad = 0;
        int first_bad = -1;
        for (int j = 0; j < len; j++)
            if (cap[start + j] !== pat(b + j)) begin
                bad++;
                if (first_bad < 0) first_bad = j;
            end
        chk(bad == 0, req, "segment bytes (mismatch count / first index)", bad, 0);
        if (bad != 0) $display("  first mismatch at byte %0d", first_bad);
    endtask

    task automatic t_reset();
        chk(!mem_req, "R12", "mem_req after reset", int'(mem_req), 0);
        chk(!frm_valid, "R12", "frm_valid after reset", int'(frm_valid), 0);
        chk(!(st_txok | st_done | st_nobuf), "R12", "status after reset",
            int'({st_txok, st_done, st_nobuf}), 0);
    endtask

    task automatic t_disabled();
        int r0 = req_cnt;
        put_desc(0, F_OWN, F_FST | F_LST | F_OK | F_FIN | 6, 32'h200);
        put_desc(1, 0, 0, 0);
        tx_en = 1'b0; dma_en = 1'b1;
        poll_once();
        repeat (20) @(negedge clk);
        tx_en = 1'b1; dma_en = 1'b0;
        poll_once();
        repeat (20) @(negedge clk);
        dma_en = 1'b1;
        repeat (20) @(negedge clk);
        chk(req_cnt == r0, "R1", "memory requests while disabled", req_cnt, r0);
        chk(desc_w0(0) == F_OWN, "R1", "desc0 untouched", desc_w0(0), F_OWN);
    endtask

    task automatic t_single();
        int c0 = cap_n, f0 = frames, o0 = ok_cnt, d0 = fin_cnt, n0 = nobuf_cnt;
        loop_en = 1'b0;
        poll_once();
        wait_nobuf(n0 + 1, "R3");
        chk(frames == f0 + 1, "R6", "frame count", frames - f0, 1);
        chk(cap_n - c0 == 6, "R6", "frame length", cap_n - c0, 6);
        chk_seg(c0, 32'h200, 6, "R2");
        chk(loop_seen == 1'b0, "R6", "loop flag", int'(loop_seen), 0);
        chk(desc_w0(0) == 0, "R4", "desc0 write-back", desc_w0(0), 0);
        chk(ok_cnt == o0 + 1, "R7", "txok pulses", ok_cnt - o0, 1);
        chk(fin_cnt == d0 + 1, "R7", "finish pulses", fin_cnt - d0, 1);
        chk(desc_w0(1) == 0, "R3", "non-owned desc1 not written", desc_w0(1), 0);
    endtask

    task automatic t_multi();
        int c0 = cap_n, f0 = frames, o0 = ok_cnt, d0 = fin_cnt, n0 = nobuf_cnt;
        put_desc(1, F_OWN, F_FST | 5, 32'h280);
        put_desc(2, F_OWN, 3, 32'h2C0);
        put_desc(3, F_OWN, F_LST | F_FIN | F_EOR | 4, 32'h300);
        loop_en = 1'b1;
        poll_once();
        wait_nobuf(n0 + 1, "R8");
        chk(frames == f0 + 1 && cap_n - c0 == 12, "R5", "gathered length",
            cap_n - c0, 12);
        chk_seg(c0, 32'h280, 5, "R5");
        chk_seg(c0 + 5, 32'h2C0, 3, "R5");
        chk_seg(c0 + 8, 32'h300, 4, "R5");
        chk(loop_seen == 1'b1, "R6", "loop flag", int'(loop_seen), 1);
        chk(ok_cnt == o0, "R7", "txok pulses without request", ok_cnt - o0, 0);
        chk(fin_cnt == d0 + 1, "R7", "finish pulses", fin_cnt - d0, 1);
        chk((desc_w0(1) | desc_w0(2) | desc_w0(3)) == 0, "R4", "three write-backs",
            desc_w0(1) | desc_w0(2) | desc_w0(3), 0);
        loop_en = 1'b0;
    endtask

    task automatic t_wrap();
        int o0 = ok_cnt, n0 = nobuf_cnt, c0 = cap_n;
        put_desc(0, F_OWN, F_FST | F_LST | F_OK | 2, 32'h340);
        poll_once();
        wait_nobuf(n0 + 1, "R8");
        chk(desc_w0(0) == 0, "R8", "slot 0 reused after wrap", desc_w0(0), 0);
        chk(ok_cnt == o0 + 1 && cap_n - c0 == 2, "R8", "frame from slot 0",
            cap_n - c0, 2);
    endtask

    task automatic t_overflow();
        int c0 = cap_n, n0 = nobuf_cnt;
        put_desc(1, F_OWN, F_FST | F_LST | F_EOR | 70, 32'h400);
        poll_once();
        wait_nobuf(n0 + 1, "R9");
        chk(cap_n - c0 == DEPTH, "R9", "truncated frame length", cap_n - c0, DEPTH);
        chk_seg(c0, 32'h400, DEPTH, "R9");
        chk(desc_w0(1) == 1, "R9", "error bit in write-back", desc_w0(1), 1);
    endtask

    task automatic t_repoll();
        int c0 = cap_n, f0 = frames, n0 = nobuf_cnt;
        put_desc(0, F_OWN, F_FST | F_LST | 4, 32'h480);
        poll_once();
        repeat (3) @(negedge clk);
        poll_once();
        wait_nobuf(n0 + 2, "R10");
        chk(frames == f0 + 1, "R10", "frames over two scans", frames - f0, 1);
        chk(cap_n - c0 == 4, "R5", "first segment empties buffer", cap_n - c0, 4);
        chk_seg(c0, 32'h480, 4, "R5");
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        for (int w = 0; w < 1024; w++)
            mem[w] = {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
        for (int i = 0; i < 8; i++) put_desc(i, 0, 0, 0);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_single();
        t_multi();
        t_wrap();
        t_overflow();
        t_repoll();
        finish_run();
    end

endmodule